// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block is the control engine of one DMA channel. Software programs the address of a list of packed 8-byte descriptors in memory. On a start request the engine reads the descriptors one at a time through a single-beat memory read port. It decodes each one into a buffer address, a byte count and three flag bits. For every descriptor that carries the transfer flag, it hands one command to a separate data mover. The data mover moves the bytes and answers with a one-cycle done strobe.

A parameter sets whether the instance serves a receive or a transmit channel. A receive instance is started by writing 1 to its enable register and halted by writing 0. It also holds a bytes-per-row value that it passes on to the data mover. A transmit instance starts as soon as its list address is written. In both variants the walk ends after the descriptor marked as the end of the list, and a completion pulse follows. A descriptor that fails the validity checks halts the walk and raises an error flag.

Top module: `sg_chain_walker`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `mem_req` and `xfer_valid` are low and `row_bytes` is zero.
- R2: A fetched 64-bit word is decoded as follows. Bits 7:0 are the flag byte: bit 0 valid, bit 1 end, bit 5 transfer. Bits 31:16 are the byte count and bits 63:32 are the buffer address, both taken little-endian from the 8 descriptor bytes. `xfer_addr` and `xfer_len` carry the decoded address and count.
- R3: The first fetch goes to the programmed list address with its three low bits cleared. Each later fetch is 8 bytes above the one before it.
- R4: While a command is outstanding, no descriptor fetch is issued. `xfer_valid`, `xfer_addr` and `xfer_len` hold steady until `xfer_done`.
- R5: After the data mover finishes the end-flagged descriptor, `done` pulses high for exactly one cycle and `busy` falls.
- R6: A descriptor whose valid bit is 0 issues no command. It ends the walk with `err` high and no `done` pulse, and `err` stays high until the next accepted start.
- R7: A descriptor whose byte count is not a multiple of 4 issues no command and ends the walk with `err` high.
- R8: A valid descriptor without the transfer flag issues no command. The walk moves on to the next descriptor, or, if the end flag is set, completes with a `done` pulse.
- R9: A receive instance starts only on a write of 1 to bit 0 of offset 0x14. Writing its list-address register at offset 0x04 does not start it. A transmit instance starts on a write to offset 0x04 and ignores writes to 0x14.
- R10: On a receive instance, writing 0 to bit 0 of offset 0x14 during a walk returns it to idle at once. The outstanding command is dropped and `done` does not pulse.
- R11: A start request that arrives while the engine is busy is ignored. The walk in progress fetches exactly the addresses it would otherwise have fetched.
- R12: Writes to the high-address register at offset 0x00 have no effect, so addressing is always 32-bit.
- R13: On a receive instance, a write to offset 0x30 sets `row_bytes` to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RW (8) | Register byte offset within the channel bank |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | One-cycle descriptor read request |
| mem_addr | output | AW (32) | Descriptor read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Descriptor word, byte 0 in bits 7:0 |
| xfer_valid | output | 1 | Transfer command outstanding |
| xfer_addr | output | AW (32) | Buffer address of the command |
| xfer_len | output | LW (16) | Byte count of the command |
| xfer_done | input | 1 | Data mover finished the command |
| row_bytes | output | 32 | Bytes-per-row value for the data mover |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last walk halted on a bad descriptor |

## Verification
The hardest case to reach is an event that overlaps a walk already in flight: a halt or a repeated start that arrives while a transfer command is outstanding. From the ports this window lasts only as long as the data mover's latency. The bench's data mover model therefore has an adjustable latency. It is stretched to tens of cycles, and the bench polls `xfer_valid` before it fires the halt or the repeated start. Fetch addresses and commands are logged and compared against the list, so an ignored start shows up as an unchanged address sequence.

// File: rtl/sg_chain_walker.sv
`timescale 1ns/1ps
module sg_chain_walker #(
  parameter bit IS_RX = 1'b1,
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [RW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [63:0]   mem_rdata,
  output logic          xfer_valid,
  output logic [AW-1:0] xfer_addr,
  output logic [LW-1:0] xfer_len,
  input  logic          xfer_done,
  output logic [31:0]   row_bytes,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam logic [RW-1:0] OFF_LO  = RW'(8'h04);
  localparam logic [RW-1:0] OFF_EN  = RW'(8'h14);
  localparam logic [RW-1:0] OFF_ROW = RW'(8'h30);
  localparam logic [AW-1:0] STRIDE  = AW'(8);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_XFER} state_t;
  state_t state;

  logic [AW-1:0] base_q, ptr;
  logic          last_q;

  wire wr_lo    = reg_wr && reg_addr == OFF_LO;
  wire wr_en    = IS_RX && reg_wr && reg_addr == OFF_EN;
  wire wr_row   = IS_RX && reg_wr && reg_addr == OFF_ROW;
  wire start_rq = IS_RX ? (wr_en && reg_wdata[0]) : wr_lo;
  wire stop_rq  = wr_en && !reg_wdata[0];

  wire [AW-1:0] next_base = wr_lo ? reg_wdata[AW-1:0] : base_q;

  wire [7:0]    d_flags = mem_rdata[7:0];
  wire [LW-1:0] d_len   = mem_rdata[16 +: LW];
  wire [AW-1:0] d_addr  = mem_rdata[32 +: AW];
  wire          d_bad   = !d_flags[0] || (d_len[1:0] != 2'b00);

  assign mem_req    = state == S_REQ;
  assign mem_addr   = ptr;
  assign xfer_valid = state == S_XFER;
  assign busy       = state != S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      row_bytes <= '0;
    end else begin
      if (wr_lo)  base_q    <= reg_wdata[AW-1:0];
      if (wr_row) row_bytes <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ptr       <= '0;
      last_q    <= 1'b0;
      xfer_addr <= '0;
      xfer_len  <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (stop_rq && state != S_IDLE) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (start_rq) begin
            ptr   <= {next_base[AW-1:3], 3'b000};
            err   <= 1'b0;
            state <= S_REQ;
          end
          S_REQ: state <= S_WAIT;
          S_WAIT: if (mem_rvalid) begin
            if (d_bad) begin
              err   <= 1'b1;
              state <= S_IDLE;
            end else begin
              last_q    <= d_flags[1];
              xfer_addr <= d_addr;
              xfer_len  <= d_len;
              if (d_flags[5]) begin
                state <= S_XFER;
              end else if (d_flags[1]) begin
                done  <= 1'b1;
                state <= S_IDLE;
              end else begin
                ptr   <= ptr + STRIDE;
                state <= S_REQ;
              end
            end
          end
          S_XFER: if (xfer_done) begin
            if (last_q) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              ptr   <= ptr + STRIDE;
              state <= S_REQ;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sg_chain_walker_chk.sv
`timescale 1ns/1ps
module sg_chain_walker_chk #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          xfer_valid,
  input logic [AW-1:0] xfer_addr,
  input logic [LW-1:0] xfer_len,
  input logic          xfer_done,
  input logic          busy,
  input logic          done,
  input logic          err
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !err && !mem_req && !xfer_valid));

  assert_fetch_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[2:0] == 3'b000);

  assert_no_fetch_in_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !xfer_valid);

  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_done && !reg_wr) |=>
      (xfer_valid && $stable(xfer_addr) && $stable(xfer_len)));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_err_no_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!done && !busy));

  assert_len_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> xfer_len[1:0] == 2'b00);
endmodule

bind sg_chain_walker sg_chain_walker_chk #(.AW(AW), .LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .mem_req(mem_req),
  .mem_addr(mem_addr), .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
  .xfer_len(xfer_len), .xfer_done(xfer_done), .busy(busy), .done(done),
  .err(err)
);

// File: tb/sg_chain_walker_tb.sv
`timescale 1ns/1ps
module sg_chain_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  int lat_lim = 2;

  logic        wr[2];
  logic [7:0]  wa[2];
  logic [31:0] wd[2];
  logic        mreq[2], mrv[2], xv[2], xd[2], bsy[2], dn[2], er[2];
  logic [31:0] maddr[2], xa[2], rowb[2];
  logic [63:0] mrd[2];
  logic [15:0] xl[2];

  logic [63:0] mem [32];

  logic [31:0] f_log[2][64];
  int          f_n[2];
  logic [31:0] c_addr[2][64];
  logic [15:0] c_len[2][64];
  int          c_fn[2][64];
  int          c_n[2];
  int          d_n[2];
  int          lat[2];

  sg_chain_walker #(.IS_RX(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr[0]), .reg_addr(wa[0]), .reg_wdata(wd[0]),
    .mem_req(mreq[0]), .mem_addr(maddr[0]), .mem_rvalid(mrv[0]), .mem_rdata(mrd[0]),
    .xfer_valid(xv[0]), .xfer_addr(xa[0]), .xfer_len(xl[0]), .xfer_done(xd[0]),
    .row_bytes(rowb[0]), .busy(bsy[0]), .done(dn[0]), .err(er[0]));

  sg_chain_walker #(.IS_RX(1'b0)) dut_tx_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr[1]), .reg_addr(wa[1]), .reg_wdata(wd[1]),
    .mem_req(mreq[1]), .mem_addr(maddr[1]), .mem_rvalid(mrv[1]), .mem_rdata(mrd[1]),
    .xfer_valid(xv[1]), .xfer_addr(xa[1]), .xfer_len(xl[1]), .xfer_done(xd[1]),
    .row_bytes(rowb[1]), .busy(bsy[1]), .done(dn[1]), .err(er[1]));

  for (genvar g = 0; g < 2; g++) begin : g_model
    initial begin
      f_n[g] = 0; c_n[g] = 0; d_n[g] = 0; lat[g] = 0;
      mrv[g] = 1'b0; mrd[g] = '0; xd[g] = 1'b0;
    end
    always @(posedge clk) begin
      mrv[g] <= mreq[g];
      mrd[g] <= mem[maddr[g][7:3]];
      if (mreq[g]) begin
        f_log[g][f_n[g] % 64] <= maddr[g];
        f_n[g] <= f_n[g] + 1;
      end
      if (dn[g]) d_n[g] <= d_n[g] + 1;
      xd[g] <= 1'b0;
      if (xv[g] && !xd[g]) begin
        if (lat[g] >= lat_lim) begin
          xd[g] <= 1'b1;
          lat[g] <= 0;
          c_addr[g][c_n[g] % 64] <= xa[g];
          c_len[g][c_n[g] % 64]  <= xl[g];
          c_fn[g][c_n[g] % 64]   <= f_n[g];
          c_n[g] <= c_n[g] + 1;
        end else lat[g] <= lat[g] + 1;
      end else if (!xv[g]) lat[g] <= 0;
    end
  end

  function automatic logic [63:0] mk(logic [7:0] fl, logic [15:0] ln, logic [31:0] ad);
    return {ad, ln, 8'h00, fl};
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regw(int ch, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr[ch] = 1'b1; wa[ch] = a; wd[ch] = d;
    @(negedge clk);
    wr[ch] = 1'b0;
  endtask

  task automatic wait_idle(int ch);
    for (int i = 0; i < 3000 && bsy[ch]; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!bsy[0] && !dn[0] && !er[0] && !mreq[0] && !xv[0], "R1 rx quiet", {bsy[0],dn[0],er[0],mreq[0],xv[0]}, 0);
    chk(!bsy[1] && !dn[1] && !er[1] && !mreq[1] && !xv[1], "R1 tx quiet", {bsy[1],dn[1],er[1],mreq[1],xv[1]}, 0);
    chk(rowb[0] == 0, "R1 row_bytes", rowb[0], 0);
  endtask

  task automatic t_rx_chain;
    int f0 = f_n[0], c0 = c_n[0], d0 = d_n[0];
    lat_lim = 3;
    mem[8]  = mk(8'h21, 16'h0100, 32'h1000_0000);
    mem[9]  = mk(8'h21, 16'h0010, 32'h89AB_CDEF);
    mem[10] = mk(8'h23, 16'hFFFC, 32'h0000_0400);
    regw(0, 8'h04, 32'h40);
    repeat (3) @(negedge clk);
    chk(!bsy[0] && f_n[0] == f0, "R9 rx lo write no start", f_n[0]-f0, 0);
    regw(0, 8'h14, 1);
    wait_idle(0);
    chk(c_n[0]-c0 == 3, "R2 command count", c_n[0]-c0, 3);
    chk(c_addr[0][c0] == 32'h1000_0000 && c_len[0][c0] == 16'h0100, "R2 cmd0", c_addr[0][c0], 32'h1000_0000);
    chk(c_addr[0][c0+1] == 32'h89AB_CDEF && c_len[0][c0+1] == 16'h0010, "R2 cmd1", c_addr[0][c0+1], 32'h89AB_CDEF);
    chk(c_addr[0][c0+2] == 32'h400 && c_len[0][c0+2] == 16'hFFFC, "R2 cmd2 len", c_len[0][c0+2], 16'hFFFC);
    for (int i = 0; i < 3; i++) begin
      chk(f_log[0][f0+i] == 32'h40 + 8*i, "R3 fetch address", f_log[0][f0+i], 32'h40 + 8*i);
      chk(c_fn[0][c0+i] - f0 == i + 1, "R4 one fetch per finished cmd", c_fn[0][c0+i]-f0, i+1);
    end
    chk(f_n[0]-f0 == 3, "R5 stops after end flag", f_n[0]-f0, 3);
    chk(d_n[0]-d0 == 1, "R5 one done pulse", d_n[0]-d0, 1);
    chk(!er[0], "R5 no err", er[0], 0);
  endtask

  task automatic t_invalid;
    int c0 = c_n[0], d0 = d_n[0];
    mem[12] = mk(8'h21, 16'h0020, 32'h2000);
    mem[13] = mk(8'h20, 16'h0020, 32'h3000);
    regw(0, 8'h04, 32'h60);
    regw(0, 8'h14, 1);
    wait_idle(0);
    chk(er[0] == 1'b1, "R6 err on invalid", er[0], 1);
    chk(c_n[0]-c0 == 1, "R6 no cmd for invalid", c_n[0]-c0, 1);
    chk(d_n[0] == d0, "R6 no done", d_n[0]-d0, 0);
  endtask

  task automatic t_misaligned;
    int c0 = c_n[0];
    mem[14] = mk(8'h23, 16'h0006, 32'h4000);
    regw(0, 8'h04, 32'h70);
    regw(0, 8'h14, 1);
    wait_idle(0);
    chk(er[0] == 1'b1 && c_n[0] == c0, "R7 misaligned length", c_n[0]-c0, 0);
  endtask

  task automatic t_skip;
    int f0 = f_n[0], c0 = c_n[0], d0 = d_n[0];
    mem[16] = mk(8'h01, 16'h0010, 32'h5000);
    mem[17] = mk(8'h23, 16'h0008, 32'h6000);
    regw(0, 8'h04, 32'h80);
    regw(0, 8'h14, 1);
    chk(er[0] == 1'b0, "R6 err cleared by start", er[0], 0);
    wait_idle(0);
    chk(c_n[0]-c0 == 1 && c_addr[0][c0] == 32'h6000, "R8 skip no-transfer entry", c_addr[0][c0], 32'h6000);
    chk(f_n[0]-f0 == 2 && d_n[0]-d0 == 1, "R8 walk continues", f_n[0]-f0, 2);
    mem[18] = mk(8'h03, 16'h0010, 32'h7000);
    c0 = c_n[0]; d0 = d_n[0];
    regw(0, 8'h04, 32'h90);
    regw(0, 8'h14, 1);
    wait_idle(0);
    chk(c_n[0] == c0 && d_n[0]-d0 == 1, "R8 end without transfer completes", d_n[0]-d0, 1);
  endtask

  task automatic t_stop;
    int c0 = c_n[0], d0 = d_n[0];
    lat_lim = 50;
    mem[20] = mk(8'h21, 16'h0040, 32'h8000);
    mem[21] = mk(8'h23, 16'h0040, 32'h9000);
    regw(0, 8'h04, 32'hA0);
    regw(0, 8'h14, 1);
    for (int i = 0; i < 100 && !xv[0]; i++) @(negedge clk);
    regw(0, 8'h14, 0);
    chk(!bsy[0] && !xv[0], "R10 halt drops walk", {bsy[0], xv[0]}, 0);
    repeat (60) @(negedge clk);
    chk(d_n[0] == d0 && c_n[0] == c0, "R10 no done after halt", d_n[0]-d0, 0);
  endtask

  task automatic t_rx_restart;
    int f0 = f_n[0], d0 = d_n[0];
    lat_lim = 20;
    regw(0, 8'h14, 1);
    regw(0, 8'h14, 1);
    for (int i = 0; i < 100 && !xv[0]; i++) @(negedge clk);
    regw(0, 8'h14, 1);
    wait_idle(0);
    chk(f_n[0]-f0 == 2, "R11 rx restart ignored count", f_n[0]-f0, 2);
    chk(f_log[0][f0] == 32'hA0 && f_log[0][f0+1] == 32'hA8, "R11 rx addresses", f_log[0][f0+1], 32'hA8);
    chk(d_n[0]-d0 == 1, "R11 one done", d_n[0]-d0, 1);
  endtask

  task automatic t_tx;
    int f0 = f_n[1], c0 = c_n[1], d0 = d_n[1];
    lat_lim = 10;
    regw(1, 8'h14, 1);
    repeat (3) @(negedge clk);
    chk(!bsy[1] && f_n[1] == f0, "R9 tx ignores enable", f_n[1]-f0, 0);
    regw(1, 8'h00, 32'hFFFF_FFFF);
    mem[24] = mk(8'h21, 16'h0004, 32'hA000);
    mem[25] = mk(8'h23, 16'h0008, 32'hB000);
    regw(1, 8'h04, 32'hC5);
    chk(bsy[1], "R9 tx starts on lo write", bsy[1], 1);
    regw(1, 8'h04, 32'h08);
    wait_idle(1);
    chk(f_n[1]-f0 == 2, "R11 tx restart ignored", f_n[1]-f0, 2);
    chk(f_log[1][f0] == 32'hC0, "R12 hi ignored, R3 aligned base", f_log[1][f0], 32'hC0);
    chk(f_log[1][f0+1] == 32'hC8, "R3 tx stride", f_log[1][f0+1], 32'hC8);
    chk(c_n[1]-c0 == 2 && c_addr[1][c0+1] == 32'hB000, "R2 tx cmd", c_addr[1][c0+1], 32'hB000);
    chk(d_n[1]-d0 == 1, "R5 tx done", d_n[1]-d0, 1);
  endtask

  task automatic t_row;
    regw(0, 8'h30, 32'd640);
    chk(rowb[0] == 32'd640, "R13 row bytes", rowb[0], 640);
    regw(1, 8'h30, 32'd99);
    chk(rowb[1] == 0, "R13 tx has no row reg", rowb[1], 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = '0;
    for (int c = 0; c < 2; c++) begin wr[c] = 1'b0; wa[c] = '0; wd[c] = '0; end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_rx_chain;
    t_invalid;
    t_misaligned;
    t_skip;
    t_stop;
    t_rx_restart;
    t_tx;
    t_row;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule